// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns a 64-bit integer operand into an IEEE-754 binary64 value in one clocked step. A 2-bit type selector says whether the operand is signed or unsigned and whether only its low 32 bits are meaningful. A precision select picks the rounding target: the value is rounded either to a 24-bit significand and then widened without loss into binary64 layout, or straight to a 53-bit significand. A 2-bit rounding-mode input selects the direction.

Along with the result the block returns a 5-bit class code and three status bits: one marks that rounding increased the significand magnitude, one marks that nonzero bits were dropped, and one requests that a sticky inexact bit be set in an outer status register. Each accepted operation replaces all of these outputs, so no flag carries over from an earlier conversion. An operation is presented with `inValid`. Its result shows up with `outValid` one clock later and stays put until the next accepted operation.

Top module: `int2fp_conv`

## Requirements
- R1: An operation accepted with `inValid` high at a rising edge appears on the outputs with `outValid` high straight after that edge. With `inValid` low, `outValid` falls and every other output holds its value. Reset clears all outputs to zero.
- R2: `srcType` encoding: 0 is signed 32-bit, 1 is unsigned 32-bit, 2 is signed 64-bit, 3 is unsigned 64-bit. For codes 0 and 1, bits 63:32 of `srcVal` are ignored.
- R3: A zero operand gives an all-zero result, class 5'b00010 and all three status bits low, whatever the type, precision or mode.
- R4: A nonzero result has class 5'b00100 when positive and 5'b01000 when negative. The sign is in result bit 63 and the biased exponent is in bits 62:52.
- R5: `rndMode` encoding: 0 rounds to nearest with ties to even, 1 rounds toward zero, 2 rounds toward +infinity, 3 rounds toward -infinity.
- R6: With `roundSingle` high the magnitude is rounded to 24 significant bits and emitted exactly in binary64 layout, so result bits 28:0 are zero.
- R7: With `roundSingle` low the magnitude is rounded to 53 significant bits.
- R8: `fracInexact` is high exactly when the discarded bits were nonzero, and `inexactReq` equals it for every result.
- R9: `fracRounded` is high exactly when rounding incremented the significand magnitude. This includes a carry that lifts the exponent by one.
- R10: An unsigned 32-bit operand rounded to 53 bits is always exact, so both `fracInexact` and `fracRounded` are low.
- R11: The most negative signed 64-bit value converts exactly to -2^63, which is 64'hC3E0000000000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation present this cycle |
| srcVal | input | 64 | Integer operand |
| srcType | input | 2 | Operand type (R2 encoding) |
| roundSingle | input | 1 | 1: round to 24-bit significand, 0: to 53-bit |
| rndMode | input | 2 | Rounding direction (R5 encoding) |
| outValid | output | 1 | Result registers hold a new result |
| result | output | 64 | binary64 result |
| resClass | output | 5 | Result class code |
| fracRounded | output | 1 | Significand was incremented by rounding |
| fracInexact | output | 1 | Discarded bits were nonzero |
| inexactReq | output | 1 | Request to set the sticky inexact bit |

## Verification
The bench targets exact ties just past 2^24 and 2^53, in both signs and all four modes. A wrong tie rule would pick the odd neighbour, and a wrong directed rule would round negative values the wrong way. All-ones operands are rounded up so that the significand carry must raise the exponent; a design that drops that carry returns a value about half the correct size. The bench also covers the most negative 32-bit and 64-bit operands, where a careless magnitude step overflows into a wrong sign or exponent. It puts nonzero upper bits on 32-bit operands, which a design that decodes the width wrongly would fold into the value.

// File: rtl/int2fp_pkg.sv
package int2fp_pkg;
  localparam int SRC_W    = 64;
  localparam int EXP_W    = 11;
  localparam int FRAC_W   = 52;
  localparam int EXP_BIAS = 1023;
  localparam int SGL_KEEP = 24;
  localparam int DBL_KEEP = 53;
  localparam int CLS_W    = 5;
  localparam int CNT_W    = $clog2(SRC_W);

  typedef enum logic [1:0] {
    SRC_S32 = 2'd0,
    SRC_U32 = 2'd1,
    SRC_S64 = 2'd2,
    SRC_U64 = 2'd3
  } srcKind_e;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'd0,
    RND_ZERO      = 2'd1,
    RND_UP        = 2'd2,
    RND_DOWN      = 2'd3
  } rndMode_e;

  localparam logic [CLS_W-1:0] CLS_POS_NORM = 5'b00100;
  localparam logic [CLS_W-1:0] CLS_NEG_NORM = 5'b01000;
  localparam logic [CLS_W-1:0] CLS_POS_ZERO = 5'b00010;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;     // load result registers this edge
    logic pickDouble;  // select 53-bit rounder
    logic signedSrc;   // operand is two's complement
    logic narrowSrc;   // only low 32 bits are meaningful
  } ctrlStrobe_t;
endpackage

// File: rtl/int2fp_ctrl.sv
module int2fp_ctrl
  import int2fp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  srcType,
  input  logic        roundSingle,
  output ctrlStrobe_t strobe,
  output logic        outValid
);
  srcKind_e kind;

  always_comb begin
    kind              = srcKind_e'(srcType);
    strobe.capture    = inValid;
    strobe.pickDouble = ~roundSingle;
    strobe.signedSrc  = (kind == SRC_S32) || (kind == SRC_S64);
    strobe.narrowSrc  = (kind == SRC_S32) || (kind == SRC_U32);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/int2fp_lzc.sv
module int2fp_lzc #(
  parameter int W  = 64,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  vecIn,
  output logic [CW-1:0] zeroCount
);
  // Highest set bit wins; all-zero input yields 0 (caller handles zero)
  always_comb begin
    zeroCount = '0;
    for (int i = 0; i < W; i++) begin
      if (vecIn[i]) zeroCount = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/int2fp_rounder.sv
module int2fp_rounder
  import int2fp_pkg::*;
#(
  parameter int W     = 64,  // width of normalised value incl. leading one
  parameter int KEEP  = 53,  // significant bits kept incl. leading one
  parameter int OUT_W = 52   // fraction field width of output format
) (
  input  logic [W-2:0]     belowLead,  // normalised value without its leading one
  input  logic             signIn,
  input  rndMode_e         mode,
  output logic [OUT_W-1:0] fracOut,
  output logic             carryOut,
  output logic             inexact,
  output logic             bumped
);
  localparam int DROP = W - KEEP;
  localparam int PAD  = OUT_W - (KEEP - 1);

  logic [KEEP-2:0] fracKept;
  logic            guardBit;
  logic            stickyBit;
  logic            inc;
  logic [KEEP-1:0] sum;

  assign fracKept  = belowLead[W-2 -: KEEP-1];
  assign guardBit  = belowLead[DROP-1];
  assign stickyBit = |belowLead[DROP-2:0];
  assign inexact   = guardBit | stickyBit;

  always_comb begin
    unique case (mode)
      RND_NEAR_EVEN: inc = guardBit & (stickyBit | fracKept[0]);
      RND_ZERO:      inc = 1'b0;
      RND_UP:        inc = ~signIn & inexact;
      RND_DOWN:      inc = signIn & inexact;
      default:       inc = 1'b0;
    endcase
  end

  // A carry out of the fraction leaves it all-zero: exactly the next power of two
  assign sum      = {1'b0, fracKept} + KEEP'(inc);
  assign carryOut = sum[KEEP-1];
  assign fracOut  = OUT_W'(sum[KEEP-2:0]) << PAD;
  assign bumped   = inc;
endmodule

// File: rtl/int2fp_datapath.sv
module int2fp_datapath
  import int2fp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [SRC_W-1:0]  srcVal,
  input  logic [1:0]        rndMode,
  output logic [SRC_W-1:0]  result,
  output logic [CLS_W-1:0]  resClass,
  output logic              fracRounded,
  output logic              fracInexact,
  output logic              inexactReq
);
  localparam int NPREC = 2;

  logic [SRC_W-1:0] widened;
  logic             negIn;
  logic [SRC_W-1:0] magnitude;
  logic [CNT_W-1:0] lzCount;
  logic [SRC_W-1:0] normVal;
  logic             nonZero;
  rndMode_e         modeSel;

  logic [FRAC_W-1:0] fracP  [NPREC];
  logic              carryP [NPREC];
  logic              inexP  [NPREC];
  logic              bumpP  [NPREC];

  logic [FRAC_W-1:0] fracSel;
  logic              carrySel, inexSel, bumpSel;
  logic [EXP_W-1:0]  expBiased;
  logic [SRC_W-1:0]  resultNext;
  logic [CLS_W-1:0]  classNext;

  // Operand extraction: sign-extend or zero-extend the narrow forms
  always_comb begin
    if (strobe.narrowSrc)
      widened = {{(SRC_W-32){strobe.signedSrc & srcVal[31]}}, srcVal[31:0]};
    else
      widened = srcVal;
    negIn     = strobe.signedSrc & widened[SRC_W-1];
    magnitude = negIn ? (~widened + SRC_W'(1)) : widened;
    modeSel   = rndMode_e'(rndMode);
  end

  int2fp_lzc #(.W(SRC_W), .CW(CNT_W)) u_lzc (
    .vecIn     (magnitude),
    .zeroCount (lzCount)
  );

  assign normVal = magnitude << lzCount;
  assign nonZero = normVal[SRC_W-1];

  // One rounder per target precision; index 0 single, 1 double
  for (genvar p = 0; p < NPREC; p++) begin : g_prec
    localparam int K = (p == 0) ? SGL_KEEP : DBL_KEEP;
    int2fp_rounder #(.W(SRC_W), .KEEP(K), .OUT_W(FRAC_W)) u_rnd (
      .belowLead (normVal[SRC_W-2:0]),
      .signIn    (negIn),
      .mode      (modeSel),
      .fracOut   (fracP[p]),
      .carryOut  (carryP[p]),
      .inexact   (inexP[p]),
      .bumped    (bumpP[p])
    );
  end

  always_comb begin
    fracSel  = strobe.pickDouble ? fracP[1]  : fracP[0];
    carrySel = strobe.pickDouble ? carryP[1] : carryP[0];
    inexSel  = strobe.pickDouble ? inexP[1]  : inexP[0];
    bumpSel  = strobe.pickDouble ? bumpP[1]  : bumpP[0];
    expBiased = EXP_W'(EXP_BIAS + SRC_W - 1) - EXP_W'(lzCount) + EXP_W'(carrySel);
    if (nonZero) begin
      resultNext = {negIn, expBiased, fracSel};
      classNext  = negIn ? CLS_NEG_NORM : CLS_POS_NORM;
    end else begin
      resultNext = '0;
      classNext  = CLS_POS_ZERO;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result      <= '0;
      resClass    <= '0;
      fracRounded <= 1'b0;
      fracInexact <= 1'b0;
      inexactReq  <= 1'b0;
    end else if (strobe.capture) begin
      result      <= resultNext;
      resClass    <= classNext;
      fracRounded <= nonZero & bumpSel;
      fracInexact <= nonZero & inexSel;
      inexactReq  <= nonZero & inexSel;
    end
  end
endmodule

// File: rtl/int2fp_conv.sv
module int2fp_conv
  import int2fp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [63:0] srcVal,
  input  logic [1:0]  srcType,
  input  logic        roundSingle,
  input  logic [1:0]  rndMode,
  output logic        outValid,
  output logic [63:0] result,
  output logic [4:0]  resClass,
  output logic        fracRounded,
  output logic        fracInexact,
  output logic        inexactReq
);
  ctrlStrobe_t strobe;

  int2fp_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .srcType     (srcType),
    .roundSingle (roundSingle),
    .strobe      (strobe),
    .outValid    (outValid)
  );

  int2fp_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .srcVal      (srcVal),
    .rndMode     (rndMode),
    .result      (result),
    .resClass    (resClass),
    .fracRounded (fracRounded),
    .fracInexact (fracInexact),
    .inexactReq  (inexactReq)
  );
endmodule

// File: rtl/int2fp_chk.sv
module int2fp_chk
  import int2fp_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [1:0]  srcType,
  input logic        roundSingle,
  input logic [1:0]  rndMode,
  input logic        outValid,
  input logic [63:0] result,
  input logic [4:0]  resClass,
  input logic        fracRounded,
  input logic        fracInexact,
  input logic        inexactReq
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result) && $stable(resClass) && $stable(fracInexact));
  a_r2_unsigned_positive: assert property (@(posedge clk) disable iff (!rstN)
    inValid && srcType[0] |=> !result[63]);
  a_r3_zero_class: assert property (@(posedge clk) disable iff (!rstN)
    outValid && result == 64'd0 |-> resClass == CLS_POS_ZERO && !fracInexact && !fracRounded);
  a_r4_sign_class: assert property (@(posedge clk) disable iff (!rstN)
    outValid && result != 64'd0 |-> resClass == (result[63] ? CLS_NEG_NORM : CLS_POS_NORM));
  a_r5_rtz_no_bump: assert property (@(posedge clk) disable iff (!rstN)
    inValid && rndMode == 2'd1 |=> !fracRounded);
  a_r6_single_widen: assert property (@(posedge clk) disable iff (!rstN)
    inValid && roundSingle |=> result[28:0] == 29'd0);
  a_r8_req_matches: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inexactReq == fracInexact);
  a_r9_rounded_inexact: assert property (@(posedge clk) disable iff (!rstN)
    outValid && fracRounded |-> fracInexact);
  a_r10_u32_exact: assert property (@(posedge clk) disable iff (!rstN)
    inValid && srcType == 2'd1 && !roundSingle |=> !fracInexact && !fracRounded);
endmodule

bind int2fp_conv int2fp_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .srcType     (srcType),
  .roundSingle (roundSingle),
  .rndMode     (rndMode),
  .outValid    (outValid),
  .result      (result),
  .resClass    (resClass),
  .fracRounded (fracRounded),
  .fracInexact (fracInexact),
  .inexactReq  (inexactReq)
);

// File: tb/sim_int2fp_conv.sv
`timescale 1ns/1ps
module sim_int2fp_conv;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] srcVal = '0;
  logic [1:0]  srcType = '0;
  logic        roundSingle = 1'b0;
  logic [1:0]  rndMode = '0;
  logic        outValid;
  logic [63:0] result;
  logic [4:0]  resClass;
  logic        fracRounded, fracInexact, inexactReq;

  always #2 clk = ~clk;  // 250 MHz

  int2fp_conv u0 (.*);

  typedef struct {
    logic [63:0] res;
    logic [4:0]  cls;
    logic        fr;
    logic        fi;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   checkCnt = 0;
  int   failCnt = 0;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Reference: locate the top bit, split kept/removed parts, decide by comparison
  function automatic exp_t refConv(input logic [63:0] v, input logic [1:0] t,
                                   input logic sgl, input logic [1:0] rm);
    exp_t        e;
    logic        neg;
    logic [63:0] x, mag, kept, rem, half;
    int          p, keepBits, sh;
    logic        up;
    e.fr = 1'b0; e.fi = 1'b0; e.tag = "";
    x   = (t[1] == 1'b0) ? {{32{~t[0] & v[31]}}, v[31:0]} : v;
    neg = ~t[0] & x[63];
    mag = neg ? (64'd0 - x) : x;
    if (mag == 64'd0) begin
      e.res = '0; e.cls = 5'b00010;
      return e;
    end
    p = 63;
    while (!mag[p]) p--;
    keepBits = sgl ? 24 : 53;
    if (p + 1 <= keepBits) begin
      kept = mag << (keepBits - 1 - p);
    end else begin
      sh   = p + 1 - keepBits;
      kept = mag >> sh;
      rem  = mag & ((64'd1 << sh) - 64'd1);
      half = 64'd1 << (sh - 1);
      e.fi = (rem != 64'd0);
      case (rm)
        2'd0:    up = (rem > half) || (rem == half && kept[0]);
        2'd1:    up = 1'b0;
        2'd2:    up = !neg && e.fi;
        default: up = neg && e.fi;
      endcase
      e.fr = up;
      kept = kept + {63'd0, up};
      if (kept[keepBits]) begin
        kept = kept >> 1;
        p++;
      end
    end
    if (sgl) kept = (kept & 64'h7F_FFFF) << 29;
    else     kept = kept & 64'h000F_FFFF_FFFF_FFFF;
    e.res = {neg, 11'(p + 1023), kept[51:0]};
    e.cls = neg ? 5'b01000 : 5'b00100;
    return e;
  endfunction

  task automatic drive(input logic [63:0] v, input logic [1:0] t, input logic sgl,
                       input logic [1:0] rm, input string tag);
    exp_t e;
    @(negedge clk);
    srcVal = v; srcType = t; roundSingle = sgl; rndMode = rm; inValid = 1'b1;
    e = refConv(v, t, sgl, rm);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // Monitor: pop expected item for every valid result
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R1", "unexpected result", result, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(result == e.res && resClass == e.cls && fracRounded == e.fr &&
              fracInexact == e.fi && inexactReq == e.fi, e.tag,
              $sformatf("cls=%b/%b fr=%b/%b fi=%b/%b req=%b result",
                        resClass, e.cls, fracRounded, e.fr, fracInexact, e.fi, inexactReq),
              result, e.res);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    exp_t held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(!outValid && result == 0 && resClass == 0 && !fracRounded && !fracInexact && !inexactReq,
          "R1", "reset state", result, 64'd0);
    rstN = 1'b1;

    // R3: zero in every type, precision and mode
    for (int t = 0; t < 4; t++)
      for (int m = 0; m < 4; m++) begin
        drive(64'd0, 2'(t), 1'b0, 2'(m), "R3");
        drive(64'd0, 2'(t), 1'b1, 2'(m), "R3");
      end
    // R2: upper bits ignored for 32-bit types, with sign per type
    drive(64'hDEADBEEF_FFFFFFFF, 2'd0, 1'b0, 2'd0, "R2 R4");
    drive(64'hDEADBEEF_FFFFFFFF, 2'd1, 1'b1, 2'd0, "R2");
    drive(64'h12345678_80000000, 2'd0, 1'b0, 2'd1, "R2 R4");
    drive(64'hFFFFFFFF_00000001, 2'd1, 1'b0, 2'd3, "R2");
    drive(64'hFFFFFFFF_FFFFFFFF, 2'd2, 1'b0, 2'd0, "R2 R4");
    // R10: unsigned 32-bit to 53 bits exact in every mode
    for (int m = 0; m < 4; m++) begin
      drive(64'hA5A5A5A5_FFFFFFFF, 2'd1, 1'b0, 2'(m), "R10");
      drive(64'h00000000_7FFFFFFF, 2'd1, 1'b0, 2'(m), "R10");
    end
    // R11: most negative signed values
    for (int m = 0; m < 4; m++) begin
      drive(64'h80000000_00000000, 2'd2, 1'b0, 2'(m), "R11");
      drive(64'h80000000_00000000, 2'd2, 1'b1, 2'(m), "R11");
      drive(64'h00000000_80000000, 2'd0, 1'b1, 2'(m), "R11");
    end
    // R5 R6 R7 R8 R9: ties and carries in all four modes, both signs
    for (int m = 0; m < 4; m++) begin
      drive((64'd1 << 53) + 64'd1, 2'd3, 1'b0, 2'(m), "R5 R7 R8");
      drive((64'd1 << 53) + 64'd3, 2'd3, 1'b0, 2'(m), "R5 R7 R9");
      drive(64'd0 - ((64'd1 << 53) + 64'd1), 2'd2, 1'b0, 2'(m), "R5 R7 R8");
      drive(64'd0 - ((64'd1 << 53) + 64'd3), 2'd2, 1'b0, 2'(m), "R5 R7 R9");
      drive((64'd1 << 24) + 64'd1, 2'd1, 1'b1, 2'(m), "R5 R6 R8");
      drive((64'd1 << 24) + 64'd3, 2'd1, 1'b1, 2'(m), "R5 R6 R9");
      drive(64'd0 - ((64'd1 << 24) + 64'd3), 2'd0, 1'b1, 2'(m), "R5 R6 R9");
      drive(64'hFFFFFFFF_FFFFFFFF, 2'd3, 1'b0, 2'(m), "R9 R7");
      drive(64'hFFFFFFFF_FFFFFFFF, 2'd3, 1'b1, 2'(m), "R9 R6");
      drive(64'h7FFFFFFF_FFFFFFFF, 2'd2, 1'b0, 2'(m), "R9 R7");
      drive(64'h00000000_7FFFFFFF, 2'd0, 1'b1, 2'(m), "R9 R6");
      drive(64'd1, 2'd2, 1'b1, 2'(m), "R4 R6");
      drive(64'hFFFFFFFF_FFFFFFFF, 2'd0, 1'b1, 2'(m), "R4 R6");
    end
    idle(2);
    check(sb.size() == 0, "R1", "directed queue drained", 64'(sb.size()), 64'd0);

    // R1: outputs hold while idle with changing inputs
    drive(64'h0000_1234_5678_9ABC, 2'd3, 1'b0, 2'd0, "R1");
    held = refConv(64'h0000_1234_5678_9ABC, 2'd3, 1'b0, 2'd0);
    @(negedge clk);
    inValid = 1'b0; srcVal = 64'hFFFF_0000_FFFF_0000; srcType = 2'd2; roundSingle = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!outValid && result == held.res && resClass == held.cls, "R1", "hold while idle",
          result, held.res);

    // Random sweep
    for (int i = 0; i < 800; i++) begin
      logic [63:0] v;
      logic        s;
      v = {$urandom(), $urandom()};
      if (i % 3 == 0) v = v >> ($urandom() % 64);
      s = 1'($urandom());
      drive(v, 2'($urandom()), s, 2'($urandom()), s ? "R5 R6 R8" : "R5 R7 R9");
    end
    idle(3);
    check(sb.size() == 0, "R1", "random queue drained", 64'(sb.size()), 64'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule